// File: doc/BRIEF.md
# Byte SPI Master with Completion and Collision Flags

This block is a single-byte SPI master that sits on a small register bus. Software writes a byte to the data register. The block shifts that byte out on MOSI, most significant bit first, and at the same time collects eight bits from MISO. The SCK rate comes from the system clock through a divider. A three-bit code selects the divider: a speed-double bit in the status register plus two rate bits in the control register.

Two sticky flags report what happened on the serial side. The done flag marks a finished byte, or a slave-select fault while in master mode. The collision flag marks a data write made while a byte was still being shifted. Both flags are cleared by the same two steps: software reads the status register while the flag is set, then touches the data register. An interrupt acknowledge pulse also clears the done flag. An interrupt line is raised from the done flag when the local enable and the global enable input are both high.

Register map: address 0 is control, address 1 is status, address 2 is data. Control bits: [7] interrupt enable, [6] block enable, [4] master select, [3] slave-select fault check, [1:0] rate bits. Status bits: [7] done flag, [6] collision flag, [5:1] read as zero, [0] speed double, which is writable.

Top module: `spi_byte_master`

## Requirements
- R1: A data write (address 2) made while idle, with control bits 6 and 4 set, starts a transfer. After 8×D clock edges, where D is the selected divisor, the transfer ends and status bit 7 (done) is set.
- R2: `irq` is high exactly when the done flag, control bit 7 and `gie` are all 1. A one-cycle `irq_ack` pulse clears the done flag.
- R3: With control bits 6, 4 and 3 set, a falling `ss_n_in` sets the done flag.
- R4: A status read that sees a flag at 1, followed by a data register read or write, clears that flag. A flag that was 0 at the status read is not cleared by the next data access.
- R5: A data write made during a transfer sets status bit 6 (collision). It does not change the byte being shifted out. If a collision write is also the clearing data access, the flag stays set.
- R6: The status register reads as {done, collision, 5'b0, dbl}. All registers reset to 0.
- R7: The divisor is set by {dbl, ctrl[1:0]}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64.
- R8: The block uses SPI mode 0. SCK idles low, MOSI carries the byte MSB first and changes on the falling edge, and MISO is sampled on the rising edge. A data read returns the last byte received.
- R9: A data write made while control bit 6 or bit 4 is 0 starts no transfer. SCK stays low and the done flag stays 0.
- R10: If a flag-setting event and a clearing data access fall on the same cycle, the setting event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears done flag |
| gie | input | 1 | Global interrupt enable |
| ss_n_in | input | 1 | Slave-select pin used as an input |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A flag can be set in the same cycle that the clearing data access arrives. The collision case is provoked by reading status during a slow transfer while the collision flag is set, then writing the data register again while the transfer is still running. The done case is provoked by arming with a status read, then issuing the data read in the cycle where `ss_n_in` falls with the fault check enabled. In both cases the flag must still read 1 afterwards, and a following ordinary read-status/access-data pair must clear it.

// File: rtl/spi_byte_master.sv
module spi_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       irq_ack,
  input  logic       gie,
  input  logic       ss_n_in,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic [7:0] ctrl, shreg, rxbuf;
  logic       dbl, done_f, coll_f, arm_done, arm_coll;
  logic       busy, sck_q, samp, flt_q;
  logic [2:0] bitcnt;
  logic [6:0] cnt, half_m1;

  always_comb begin
    case ({dbl, ctrl[1:0]})
      3'b000:  half_m1 = 7'd1;
      3'b001:  half_m1 = 7'd7;
      3'b010:  half_m1 = 7'd31;
      3'b011:  half_m1 = 7'd63;
      3'b100:  half_m1 = 7'd0;
      3'b101:  half_m1 = 7'd3;
      3'b110:  half_m1 = 7'd15;
      default: half_m1 = 7'd31;
    endcase
  end

  wire wr_data  = wr_en && addr == A_DATA;
  wire data_acc = (wr_en || rd_en) && addr == A_DATA;
  wire rd_stat  = rd_en && addr == A_STAT;
  wire start    = wr_data && !busy && ctrl[6] && ctrl[4];
  wire collide  = wr_data && busy;
  wire tick     = busy && cnt == half_m1;
  wire done     = tick && sck_q && bitcnt == 3'd7;
  wire flt      = ctrl[6] && ctrl[4] && ctrl[3] && !ss_n_in;
  wire flt_set  = flt && !flt_q;

  assign sck  = sck_q;
  assign mosi = shreg[7];
  assign irq  = done_f && ctrl[7] && gie;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl;
      A_STAT:  rdata = {done_f, coll_f, 5'b0, dbl};
      A_DATA:  rdata = rxbuf;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; dbl <= 1'b0; flt_q <= 1'b0;
      done_f <= 1'b0; coll_f <= 1'b0; arm_done <= 1'b0; arm_coll <= 1'b0;
    end else begin
      flt_q <= flt;
      if (wr_en && addr == A_CTRL) ctrl <= wdata;
      if (wr_en && addr == A_STAT) dbl <= wdata[0];

      if (done || flt_set) done_f <= 1'b1;
      else if (irq_ack || (data_acc && arm_done)) done_f <= 1'b0;

      if (collide) coll_f <= 1'b1;
      else if (data_acc && arm_coll) coll_f <= 1'b0;

      if (rd_stat) begin
        arm_done <= done_f;
        arm_coll <= coll_f;
      end else if (data_acc) begin
        arm_done <= 1'b0;
        arm_coll <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sck_q <= 1'b0; samp <= 1'b0;
      shreg <= '0; rxbuf <= '0; bitcnt <= '0; cnt <= '0;
    end else if (start) begin
      busy <= 1'b1; sck_q <= 1'b0; shreg <= wdata; bitcnt <= '0; cnt <= '0;
    end else if (busy) begin
      if (!tick) cnt <= cnt + 7'd1;
      else begin
        cnt <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          samp  <= miso;
        end else begin
          sck_q  <= 1'b0;
          shreg  <= {shreg[6:0], samp};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            busy  <= 1'b0;
            rxbuf <= {shreg[6:0], samp};
          end
        end
      end
    end
  end

  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done_f); // R1
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack && !busy && !flt) |=> !irq); // R2
  AST_COLLIDE_SETS: assert property (@(posedge clk) disable iff (!rst_n) collide |=> coll_f); // R5
  AST_NO_UNARMED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (done_f && data_acc && !arm_done && !irq_ack) |=> done_f); // R4
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (addr == A_STAT) |-> rdata[5:1] == 5'b0); // R6
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck); // R8
endmodule

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, irq_ack = 0, gie = 0, ss_n_in = 1, miso;
  logic [7:0] wdata = 0, rdata;
  logic irq, sck, mosi;
  int total = 0, bad = 0;
  logic [7:0] slv = 0, cap = 0;

  always #10 clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .irq_ack(irq_ack), .gie(gie),
    .ss_n_in(ss_n_in), .sck(sck), .mosi(mosi), .miso(miso));

  assign miso = slv[7];
  always @(negedge sck) slv <= {slv[6:0], 1'b0};
  always @(posedge sck) cap <= {cap[6:0], mosi};

  // {code, tx, slave byte}
  localparam logic [18:0] VEC [7] = '{
    {3'b000, 8'hA5, 8'h3C}, {3'b001, 8'h0F, 8'hF0}, {3'b100, 8'h81, 8'h7E},
    {3'b101, 8'hC3, 8'h5A}, {3'b110, 8'h12, 8'h34}, {3'b011, 8'hFF, 8'h00},
    {3'b111, 8'h55, 8'hAA}};

  function automatic int divof(input logic [2:0] c);
    case (c)
      3'b000: return 4;   3'b001: return 16; 3'b010: return 64; 3'b011: return 128;
      3'b100: return 2;   3'b101: return 8;  3'b110: return 32; default: return 64;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(posedge clk); @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    idle(2);
    chk("R6 sck reset", {31'b0, sck}, 0);
    chk("R2 irq reset", {31'b0, irq}, 0);
    rst_n = 1;
    rd(0, v); chk("R6 ctrl reset", v, 8'h00);
    rd(1, v); chk("R6 status reset", v, 8'h00);

    wr(2, 8'h99); idle(40);
    chk("R9 sck idle when disabled", {31'b0, sck}, 0);
    rd(1, v); chk("R9 no done when disabled", v, 8'h00);

    gie = 1;
    for (int k = 0; k < 7; k++) begin
      wr(0, {2'b11, 4'b0100, VEC[k][17:16]});
      wr(1, {7'b0, VEC[k][18]});
      slv = VEC[k][7:0];
      wr(2, VEC[k][15:8]);
      n = 0;
      while (!irq && n < 3000) begin @(negedge clk); n++; end
      chk("R7 R1 transfer length", n, 8 * divof(VEC[k][18:16]));
      chk("R8 mosi byte", cap, VEC[k][15:8]);
      rd(1, v); chk("R1 R6 status done", v, {1'b1, 6'b0, VEC[k][18]});
      rd(2, v); chk("R8 received byte", v, VEC[k][7:0]);
      rd(1, v); chk("R4 cleared by sequence", v[7:6], 2'b00);
    end

    wr(1, 8'h00);
    wr(0, 8'h50);
    slv = 8'h00;
    wr(2, 8'hA5); idle(3);
    wr(2, 8'h3C);
    rd(1, v); chk("R5 collision flag", v, 8'h40);
    rd(1, v);
    idle(40);
    chk("R5 shifted byte kept", cap, 8'hA5);
    rd(1, v); chk("R4 done after status read", v, 8'hC0);
    rd(2, v);
    rd(1, v); chk("R4 both cleared", v, 8'h00);

    wr(2, 8'h11);
    rd(1, v);
    idle(40);
    rd(2, v);
    rd(1, v); chk("R4 flag set after status read not cleared", v[7], 1);
    rd(2, v);

    wr(0, 8'h53);
    wr(2, 8'h22); idle(3);
    wr(2, 8'h33);
    rd(1, v); chk("R5 collision set slow", v[6], 1);
    wr(2, 8'h44);
    rd(1, v); chk("R10 collision set wins over clear", v[6], 1);
    idle(1100);
    rd(1, v); rd(2, v);
    rd(1, v); chk("R4 cleared after slow", v, 8'h00);

    wr(0, 8'hD8); gie = 0;
    @(negedge clk); ss_n_in = 0; idle(2);
    rd(1, v); chk("R3 fault sets done", v[7], 1);
    chk("R2 gie masks irq", {31'b0, irq}, 0);
    gie = 1; #1;
    chk("R2 irq with gie", {31'b0, irq}, 1);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R2 ack clears irq", {31'b0, irq}, 0);
    ss_n_in = 1; idle(2);
    @(negedge clk); ss_n_in = 0; idle(1); ss_n_in = 1; idle(1);
    rd(1, v);
    @(negedge clk); addr = 2; rd_en = 1; ss_n_in = 0;
    @(posedge clk); @(negedge clk); rd_en = 0;
    rd(1, v); chk("R10 fault set wins over clear", v[7], 1);
    rd(2, v);
    rd(1, v); chk("R4 fault flag cleared", v[7], 0);
    ss_n_in = 1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule